// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Primary-Clock Realignment

This block turns a double-rate serial input into bit pairs on each of a set of lanes. Each lane's pin is sampled on the rising edge of a primary clock and on the rising edge of a secondary clock, which is normally the inverse of the primary. The bit taken on the primary edge sits at an even position in the serial stream. The bit taken on the secondary edge sits at an odd position. A second register, clocked by the primary clock, can retime the secondary sample. The fabric then receives both bits of a pair on the same primary edge and never has to cross a half-cycle boundary itself.

Two plain control inputs shape the output. One selects whether the odd bit comes straight from the secondary-clock register (raw) or from the retiming register (realigned). The other chooses which of the two output ports carries the even bit and which carries the odd bit.

A pin stream cannot be stalled, so the outputs have no valid/ready handshake and no back-pressure. A new pair is presented on every primary rising edge, and the consumer must take it in that cycle.

Top module: `ddr_capture_realign`

## Requirements
- R1: With the even-first ordering and reset low, the even output of a lane equals the pin value at the most recent rising edge of the primary clock.
- R2: With realign_en = 0, the odd output equals the pin value at the most recent rising edge of the secondary clock, so it changes half a primary period after the even output.
- R3: With realign_en = 1, the odd output equals the value the secondary register held just before the most recent primary rising edge. It does not change at a secondary edge.
- R4: Realigned pairing: if the stream bits d, d+1, d+2, ... are placed so that d is sampled by a primary edge, then the pair presented at that edge is d on the even output and d-1 on the odd output. Directly after reset, d-1 reads 0.
- R5: With odd_first = 0, out_first carries the even bit and out_second carries the odd bit. With odd_first = 1 the two are exchanged.
- R6: Reset is synchronous and active high. A primary edge with rst = 1 clears the even register and the retiming register, and a secondary edge with rst = 1 clears the raw odd register. Both outputs then read 0 in either mode.
- R7: Lanes are independent. Bit i of every output is derived only from pin_in[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary capture clock; all realigned outputs change on its rising edge |
| clk_sec | input | 1 | Secondary capture clock, nominally the inverse of clk_pri |
| rst | input | 1 | Synchronous active-high reset, sampled by each clock for its own registers |
| realign_en | input | 1 | 0: odd bit taken raw from the secondary register; 1: odd bit taken from the retiming register |
| odd_first | input | 1 | 0: even bit on out_first; 1: odd bit on out_first |
| pin_in | input | LANES | Double-rate serial input, one bit per lane |
| out_first | output | LANES | First bit of each lane's pair, chosen by odd_first |
| out_second | output | LANES | Second bit of each lane's pair, chosen by odd_first |

## Verification
Each result is due at a fixed point. The even bit and the realigned odd bit are due one register after the primary rising edge that follows the bit's arrival. The raw odd bit is due one register after the secondary rising edge, half a period later. The bench drives pin bits 1 ns after every clock edge and samples 0.5 ns after each primary and each secondary rising edge. At the secondary sample, a realigned odd bit must still show the older value while a raw odd bit must already show the new one, and this difference is how the half-period offset is checked. Mode and ordering inputs are re-drawn at random between pairs, because the outputs must reflect them before the next primary edge.

// File: rtl/ddr_cap_pkg.sv
`timescale 1ns/1ps
package ddr_cap_pkg;

  // Source of the odd-position bit
  typedef enum logic {
    ODD_RAW     = 1'b0,
    ODD_RETIMED = 1'b1
  } odd_src_e;

  // Which bit leads on the output pair
  typedef enum logic {
    EVEN_FIRST = 1'b0,
    ODD_FIRST  = 1'b1
  } pair_order_e;

  // Register taps of one lane
  typedef struct packed {
    logic even_bit;
    logic odd_raw;
    logic odd_retimed;
  } lane_taps_t;

endpackage

// File: rtl/ddr_lane_capture.sv
`timescale 1ns/1ps
module ddr_lane_capture
  import ddr_cap_pkg::*;
(
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       rst,
  input  logic       pin_i,
  output lane_taps_t taps_o
);

  logic even_q;
  logic odd_q;
  logic odd_rt_q;

  // Primary domain: even sample and retimed copy of the odd sample
  always_ff @(posedge clk_pri) begin
    if (rst) begin
      even_q   <= 1'b0;
      odd_rt_q <= 1'b0;
    end else begin
      even_q   <= pin_i;
      odd_rt_q <= odd_q;
    end
  end

  // Secondary domain: odd sample
  always_ff @(posedge clk_sec) begin
    if (rst) odd_q <= 1'b0;
    else     odd_q <= pin_i;
  end

  assign taps_o = '{even_bit: even_q, odd_raw: odd_q, odd_retimed: odd_rt_q};

  // R1
  even_capture_chk: assert property (@(posedge clk_pri) disable iff (rst)
    !$past(rst) |-> (even_q == $past(pin_i)));

  // R2
  odd_capture_chk: assert property (@(posedge clk_sec) disable iff (rst)
    !$past(rst) |-> (odd_q == $past(pin_i)));

  // R3
  retime_chk: assert property (@(posedge clk_pri) disable iff (rst)
    !$past(rst) |-> (odd_rt_q == $past(odd_q)));

  // R6
  pri_reset_chk: assert property (@(posedge clk_pri) disable iff (rst)
    $past(rst) |-> (even_q == 1'b0 && odd_rt_q == 1'b0));

  // R6
  sec_reset_chk: assert property (@(posedge clk_sec) disable iff (rst)
    $past(rst) |-> (odd_q == 1'b0));

endmodule

// File: rtl/ddr_pair_order.sv
`timescale 1ns/1ps
module ddr_pair_order
  import ddr_cap_pkg::*;
#(
  parameter int LANES = 2
) (
  input  lane_taps_t [LANES-1:0] taps_i,
  input  odd_src_e               src_sel,
  input  pair_order_e            order_sel,
  output logic [LANES-1:0]       first_o,
  output logic [LANES-1:0]       second_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic odd_bit;
    always_comb begin
      odd_bit = (src_sel == ODD_RETIMED) ? taps_i[g].odd_retimed : taps_i[g].odd_raw;
      if (order_sel == ODD_FIRST) begin
        first_o[g]  = odd_bit;
        second_o[g] = taps_i[g].even_bit;
      end else begin
        first_o[g]  = taps_i[g].even_bit;
        second_o[g] = odd_bit;
      end
    end
  end

endmodule

// File: rtl/ddr_capture_realign.sv
`timescale 1ns/1ps
module ddr_capture_realign
  import ddr_cap_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_pri,
  input  logic             clk_sec,
  input  logic             rst,
  input  logic             realign_en,
  input  logic             odd_first,
  input  logic [LANES-1:0] pin_in,
  output logic [LANES-1:0] out_first,
  output logic [LANES-1:0] out_second
);

  lane_taps_t [LANES-1:0] taps;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    ddr_lane_capture u_lane (
      .clk_pri (clk_pri),
      .clk_sec (clk_sec),
      .rst     (rst),
      .pin_i   (pin_in[g]),
      .taps_o  (taps[g])
    );
  end

  ddr_pair_order #(.LANES(LANES)) u_order (
    .taps_i    (taps),
    .src_sel   (odd_src_e'(realign_en)),
    .order_sel (pair_order_e'(odd_first)),
    .first_o   (out_first),
    .second_o  (out_second)
  );

endmodule

// File: tb/ddr_capture_realign_bench.sv
`timescale 1ns/1ps
module ddr_capture_realign_bench;

  localparam int L = 2;

  logic         clk_pri = 1'b0;
  logic         clk_sec;
  logic         rst;
  logic         realign_en;
  logic         odd_first;
  logic [L-1:0] pin_in;
  logic [L-1:0] out_first;
  logic [L-1:0] out_second;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;
  logic [L-1:0] last_odd;

  always #2.5 clk_pri = ~clk_pri;
  assign clk_sec = ~clk_pri;

  ddr_capture_realign #(.LANES(L)) u_ddr_capture_realign (
    .clk_pri    (clk_pri),
    .clk_sec    (clk_sec),
    .rst        (rst),
    .realign_en (realign_en),
    .odd_first  (odd_first),
    .pin_in     (pin_in),
    .out_first  (out_first),
    .out_second (out_second)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pick_first(input logic sw, input logic [L-1:0] ev, input logic [L-1:0] od);
    return sw ? od : ev;
  endfunction

  function automatic logic [L-1:0] pick_second(input logic sw, input logic [L-1:0] ev, input logic [L-1:0] od);
    return sw ? ev : od;
  endfunction

  // Starts 0.5 ns after a secondary rising edge; ends at the same point one period later.
  task automatic do_pair(input logic [L-1:0] ev, input logic [L-1:0] od, input string tag);
    logic [L-1:0] odd_exp;
    #0.5 pin_in = ev;
    @(posedge clk_pri) #0.5;
    // R1 R4 R5: pair at primary edge is (d, d-1) in both modes
    chk({tag, " R1 R5 first@pri"},  out_first,  pick_first(odd_first, ev, last_odd));
    chk({tag, " R4 R5 second@pri"}, out_second, pick_second(odd_first, ev, last_odd));
    #0.5 pin_in = od;
    @(posedge clk_sec) #0.5;
    // R2 raw odd updates now; R3 realigned odd holds
    odd_exp = realign_en ? last_odd : od;
    chk({tag, realign_en ? " R3 first@sec" : " R2 first@sec"},  out_first,  pick_first(odd_first, ev, odd_exp));
    chk({tag, realign_en ? " R3 second@sec" : " R2 second@sec"}, out_second, pick_second(odd_first, ev, odd_exp));
    last_odd = od;
  endtask

  task automatic check_zero(input string tag);
    for (int m = 0; m < 4; m++) begin
      realign_en = m[0];
      odd_first  = m[1];
      #0.05;
      chk({tag, " R6 first zero"},  out_first,  '0);
      chk({tag, " R6 second zero"}, out_second, '0);
    end
  endtask

  task automatic do_reset();
    logic sv_re, sv_of;
    sv_re = realign_en;
    sv_of = odd_first;
    #0.5 rst = 1'b1;
    pin_in = L'($urandom);
    @(posedge clk_pri) #0.5 pin_in = ~pin_in;
    @(posedge clk_sec) #0.5;
    check_zero("mid-run reset");
    rst = 1'b0;
    pin_in = '0;
    last_odd = '0;
    realign_en = sv_re;
    odd_first = sv_of;
  endtask

  initial begin
    void'($urandom(32'd7351));
    rst = 1'b1;
    pin_in = '0;
    realign_en = 1'b1;
    odd_first = 1'b0;
    repeat (3) @(posedge clk_sec);
    #0.5;
    check_zero("reset state");
    realign_en = 1'b1;
    odd_first = 1'b0;
    rst = 1'b0;
    last_odd = '0;

    // Directed, realigned: first pair after reset shows d-1 = 0 (R4)
    do_pair(2'b11, 2'b00, "dir realign R4 start");
    do_pair(2'b10, 2'b01, "dir realign R7 lanes");
    do_pair(2'b01, 2'b10, "dir realign");
    do_pair(2'b00, 2'b11, "dir realign");

    // Directed, raw
    realign_en = 1'b0;
    do_pair(2'b11, 2'b00, "dir raw");
    do_pair(2'b00, 2'b11, "dir raw");
    do_pair(2'b10, 2'b10, "dir raw R7");

    // Directed, swapped order
    odd_first = 1'b1;
    do_pair(2'b01, 2'b10, "dir swap raw R5");
    realign_en = 1'b1;
    do_pair(2'b11, 2'b01, "dir swap realign R5");
    do_pair(2'b00, 2'b10, "dir swap realign R5");

    // Mid-run reset, then the pairing restarts with 0 as d-1
    do_reset();
    do_pair(2'b10, 2'b11, "after reset R4");

    // Random streams with modes re-drawn every pair (R7 lanes carry independent bits)
    for (int i = 0; i < 400; i++) begin
      realign_en = 1'($urandom);
      odd_first  = 1'($urandom);
      do_pair(L'($urandom), L'($urandom), "rand R7");
      if (i == 200) begin
        do_reset();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule